// File: doc/BRIEF.md
# Speculative Load Alias Detector

This block guards loads that a scheduler has hoisted above earlier stores. When such a load is issued in its protected form, the block remembers the byte range it read, given as a start address and an access size, in one of a small set of numbered slots. Later, every store issued in its masked form presents its own byte range and a slot mask. The block compares that range against each selected, occupied slot. If any byte is shared, it signals an alias fault in the same cycle and names the lowest-numbered slot that matched.

Software empties the whole table with a single clear strobe when it commits or rolls back a speculative region. Ordinary loads and stores never reach this block. Cache access, the data path and the fault handler all sit outside it.

Top module: `alias_guard_top`

## Requirements
- R1: After reset every slot is empty, so no check raises `fault`.
- R2: A cycle with `rec_valid` high and `clr` low writes `rec_addr` and `rec_size` into slot `rec_idx` and marks that slot occupied. It replaces whatever the slot held before.
- R3: Size codes mean 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. A range covers the bytes from its address up to address + bytes - 1. A store matches a slot when the two ranges share at least one byte.
- R4: Only slots whose bit is set in `chk_mask` take part in a check. Bit i selects slot i.
- R5: `fault` is combinational. It is high only in a cycle where `chk_valid` is high and some slot matches. `fault_idx` is 0 whenever `fault` is low.
- R6: When several slots match, `fault_idx` gives the lowest-numbered one.
- R7: A cycle with `clr` high empties every slot from the next cycle on. A record issued in the same cycle is discarded.
- R8: A check always sees the table as it stood before the current cycle's record or clear takes effect.
- R9: An input with its strobe low has no effect. This applies to `rec_valid` low (no slot changes) and to `chk_valid` low (no fault).
- R10: Ranges do not wrap past the top of the 32-bit address space. A slot ending at or beyond 0xFFFFFFFF does not match address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rec_valid | input | 1 | Protected-load record strobe |
| rec_idx | input | 3 | Slot to write |
| rec_addr | input | 32 | Load start address |
| rec_size | input | 2 | Load size code |
| chk_valid | input | 1 | Masked-store check strobe |
| chk_addr | input | 32 | Store start address |
| chk_size | input | 2 | Store size code |
| chk_mask | input | 8 | Slots to compare |
| clr | input | 1 | Empty all slots |
| fault | output | 1 | Alias detected this cycle |
| fault_idx | output | 3 | Lowest matching slot |

## Verification
The assertions run on every cycle. They check that a fault only appears alongside a check strobe and on a slot the mask selects and that holds a real hit, and that no lower slot also hit. They also check that a clear empties the table and that a record lands in the named slot. The overlap arithmetic itself, the edge cases one byte apart, the behaviour when a record or clear shares a cycle with a check, and the non-wrapping top of memory can only be shown by the bench's directed scenarios with known addresses.

// File: rtl/alias_pkg.sv
package alias_pkg;
    parameter int unsigned ALIAS_ADDR_W = 32;
    localparam int unsigned ALIAS_SPAN_W = ALIAS_ADDR_W + 1;

    typedef logic [ALIAS_ADDR_W-1:0] addr_t;
    typedef logic [1:0]              size_code_t;

    function automatic logic [ALIAS_SPAN_W-1:0] span_end(addr_t a, size_code_t s);
        return {1'b0, a} + (ALIAS_SPAN_W'(1) << s);
    endfunction
endpackage

// File: rtl/alias_slot_table.sv
module alias_slot_table
    import alias_pkg::*;
#(
    parameter int unsigned N_SLOTS = 8,
    localparam int unsigned IDX_W  = $clog2(N_SLOTS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rec_valid,
    input  logic [IDX_W-1:0]             rec_idx,
    input  addr_t                        rec_addr,
    input  size_code_t                   rec_size,
    input  logic                         clr,
    output logic [N_SLOTS-1:0]           valid_o,
    output addr_t      [N_SLOTS-1:0]     addr_o,
    output size_code_t [N_SLOTS-1:0]     size_o
);
    typedef struct packed {
        logic [N_SLOTS-1:0]       valid;
        addr_t      [N_SLOTS-1:0] addr;
        size_code_t [N_SLOTS-1:0] size;
    } table_t;

    table_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (clr) begin
            tbl_d.valid = '0;
        end else if (rec_valid) begin
            tbl_d.valid[rec_idx] = 1'b1;
            tbl_d.addr[rec_idx]  = rec_addr;
            tbl_d.size[rec_idx]  = rec_size;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign valid_o = tbl_q.valid;
    assign addr_o  = tbl_q.addr;
    assign size_o  = tbl_q.size;

    // R7: clear empties everything next cycle
    assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (valid_o == '0));
    // R2: record lands in named slot
    assert_record_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !clr) |=> (valid_o[$past(rec_idx)] &&
                                 addr_o[$past(rec_idx)] == $past(rec_addr) &&
                                 size_o[$past(rec_idx)] == $past(rec_size)));
    // R9: no strobe, no change
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rec_valid && !clr) |=> $stable(valid_o));
endmodule

// File: rtl/alias_range_cmp.sv
module alias_range_cmp
    import alias_pkg::*;
#(
    parameter int unsigned N_SLOTS = 8
) (
    input  logic [N_SLOTS-1:0]       valid_i,
    input  addr_t      [N_SLOTS-1:0] addr_i,
    input  size_code_t [N_SLOTS-1:0] size_i,
    input  logic                     chk_valid,
    input  addr_t                    chk_addr,
    input  size_code_t               chk_size,
    input  logic [N_SLOTS-1:0]       chk_mask,
    output logic [N_SLOTS-1:0]       hit_o
);
    logic [ALIAS_SPAN_W-1:0] st_lo, st_hi;

    assign st_lo = {1'b0, chk_addr};
    assign st_hi = span_end(chk_addr, chk_size);

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        logic [ALIAS_SPAN_W-1:0] en_lo, en_hi;
        logic                    overlap;
        assign en_lo   = {1'b0, addr_i[g]};
        assign en_hi   = span_end(addr_i[g], size_i[g]);
        assign overlap = (st_lo < en_hi) && (en_lo < st_hi);
        assign hit_o[g] = chk_valid && chk_mask[g] && valid_i[g] && overlap;
    end
endmodule

// File: rtl/alias_low_pick.sv
module alias_low_pick #(
    parameter int unsigned N_SLOTS = 8,
    localparam int unsigned IDX_W  = $clog2(N_SLOTS)
) (
    input  logic [N_SLOTS-1:0] req_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/alias_guard_top.sv
module alias_guard_top
    import alias_pkg::*;
#(
    parameter int unsigned N_SLOTS = 8,
    localparam int unsigned IDX_W  = $clog2(N_SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rec_valid,
    input  logic [IDX_W-1:0]   rec_idx,
    input  logic [31:0]        rec_addr,
    input  logic [1:0]         rec_size,
    input  logic               chk_valid,
    input  logic [31:0]        chk_addr,
    input  logic [1:0]         chk_size,
    input  logic [N_SLOTS-1:0] chk_mask,
    input  logic               clr,
    output logic               fault,
    output logic [IDX_W-1:0]   fault_idx
);
    logic [N_SLOTS-1:0]       slot_valid;
    addr_t      [N_SLOTS-1:0] slot_addr;
    size_code_t [N_SLOTS-1:0] slot_size;
    logic [N_SLOTS-1:0]       hit_vec;

    alias_slot_table #(.N_SLOTS(N_SLOTS)) table_i (
        .clk(clk), .rst_n(rst_n),
        .rec_valid(rec_valid), .rec_idx(rec_idx),
        .rec_addr(rec_addr), .rec_size(rec_size), .clr(clr),
        .valid_o(slot_valid), .addr_o(slot_addr), .size_o(slot_size)
    );

    alias_range_cmp #(.N_SLOTS(N_SLOTS)) cmp_i (
        .valid_i(slot_valid), .addr_i(slot_addr), .size_i(slot_size),
        .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_size(chk_size),
        .chk_mask(chk_mask), .hit_o(hit_vec)
    );

    alias_low_pick #(.N_SLOTS(N_SLOTS)) pick_i (
        .req_i(hit_vec), .any_o(fault), .idx_o(fault_idx)
    );

    // R5: fault needs a check strobe
    assert_fault_needs_check_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> chk_valid);
    // R4: reported slot is selected by the mask and occupied
    assert_fault_in_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (chk_mask[fault_idx] && slot_valid[fault_idx]));
    // R6: reported slot hit and nothing lower did
    assert_lowest_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (hit_vec[fault_idx] &&
                   ((hit_vec & ((N_SLOTS'(1) << fault_idx) - N_SLOTS'(1))) == '0)));
    // R5: index idles at zero
    assert_idx_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> (fault_idx == '0));
    // R1: first cycle after reset sees an empty table
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !fault);
endmodule

// File: tb/alias_guard_top_tb.sv
module alias_guard_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rec_valid = 1'b0;
    logic [2:0]  rec_idx = '0;
    logic [31:0] rec_addr = '0;
    logic [1:0]  rec_size = '0;
    logic        chk_valid = 1'b0;
    logic [31:0] chk_addr = '0;
    logic [1:0]  chk_size = '0;
    logic [7:0]  chk_mask = '0;
    logic        clr = 1'b0;
    logic        fault;
    logic [2:0]  fault_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    alias_guard_top dut_i (.*);

    // One cycle: drive at negedge, compare before the next posedge.
    task automatic step(input logic rv, input logic [2:0] ri, input logic [31:0] ra,
                        input logic [1:0] rs, input logic cv, input logic [31:0] ca,
                        input logic [1:0] cs, input logic [7:0] cm, input logic cl,
                        input logic ef, input logic [2:0] ei, input string tag);
        @(negedge clk);
        rec_valid = rv; rec_idx = ri; rec_addr = ra; rec_size = rs;
        chk_valid = cv; chk_addr = ca; chk_size = cs; chk_mask = cm; clr = cl;
        #2;
        n_chk++;
        if (fault !== ef || fault_idx !== ei) begin
            n_bad++;
            $display("FAIL %s: fault=%0b idx=%0d expected fault=%0b idx=%0d",
                     tag, fault, fault_idx, ef, ei);
        end
    endtask

    task automatic rec(input logic [2:0] i, input logic [31:0] a, input logic [1:0] s);
        step(1, i, a, s, 0, 0, 0, 0, 0, 0, 0, "R9 record cycle has no fault");
    endtask

    task automatic chk(input logic [31:0] a, input logic [1:0] s, input logic [7:0] m,
                       input logic ef, input logic [2:0] ei, input string tag);
        step(0, 0, 0, 0, 1, a, s, m, 0, ef, ei, tag);
    endtask

    task automatic t_reset();
        chk(32'h0, 2'd3, 8'hFF, 0, 0, "R1 empty after reset");
        chk(32'h100, 2'd3, 8'hFF, 0, 0, "R1 empty after reset b");
    endtask

    task automatic t_overlap();
        rec(3, 32'h100, 2'd2);                        // 0x100..0x103
        chk(32'h103, 2'd0, 8'hFF, 1, 3, "R3 last byte");
        chk(32'h104, 2'd0, 8'hFF, 0, 0, "R3 one past end");
        chk(32'h0FE, 2'd1, 8'hFF, 0, 0, "R3 two bytes just below");
        chk(32'h0FF, 2'd1, 8'hFF, 1, 3, "R3 straddles start");
        chk(32'h0F8, 2'd3, 8'hFF, 0, 0, "R3 eight bytes just below");
        chk(32'h0FC, 2'd3, 8'hFF, 1, 3, "R3 eight bytes covering");
    endtask

    task automatic t_mask();
        chk(32'h100, 2'd0, 8'hF7, 0, 0, "R4 slot masked off");
        chk(32'h100, 2'd0, 8'h08, 1, 3, "R4 slot selected alone");
    endtask

    task automatic t_priority();
        rec(5, 32'h100, 2'd0);
        rec(1, 32'h200, 2'd0);
        rec(6, 32'h100, 2'd3);
        chk(32'h100, 2'd0, 8'hFF, 1, 3, "R6 lowest of 3,5,6");
        chk(32'h100, 2'd0, 8'hE0, 1, 5, "R6 lowest of 5,6");
        chk(32'h100, 2'd0, 8'h40, 1, 6, "R6 only 6");
        chk(32'h200, 2'd0, 8'hFF, 1, 1, "R6 slot 1 alone");
    endtask

    task automatic t_overwrite();
        rec(3, 32'h400, 2'd0);
        chk(32'h101, 2'd0, 8'h08, 0, 0, "R2 old range gone");
        chk(32'h400, 2'd0, 8'h08, 1, 3, "R2 new range present");
    endtask

    task automatic t_strobes();
        step(0, 0, 0, 0, 0, 32'h400, 2'd0, 8'hFF, 0, 0, 0, "R9 check strobe low");
        step(0, 0, 32'h800, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R9 record strobe low");
        chk(32'h800, 2'd0, 8'h01, 0, 0, "R9 unstrobed record absent");
    endtask

    task automatic t_same_cycle();
        step(1, 0, 32'h900, 2'd0, 1, 32'h900, 2'd0, 8'h01, 0, 0, 0, "R8 check before record");
        chk(32'h900, 2'd0, 8'h01, 1, 0, "R8 record visible next cycle");
    endtask

    task automatic t_clear();
        step(1, 2, 32'hA00, 2'd0, 1, 32'h900, 2'd0, 8'hFF, 1, 1, 0, "R8 check before clear");
        chk(32'h900, 2'd0, 8'hFF, 0, 0, "R7 cleared");
        chk(32'hA00, 2'd0, 8'hFF, 0, 0, "R7 clear beats record");
        chk(32'h100, 2'd3, 8'hFF, 0, 0, "R7 all slots empty");
    endtask

    task automatic t_top();
        rec(7, 32'hFFFF_FFFC, 2'd3);
        chk(32'h0, 2'd0, 8'h80, 0, 0, "R10 no wrap to zero");
        chk(32'hFFFF_FFFF, 2'd0, 8'h80, 1, 7, "R10 top byte");
        chk(32'hFFFF_FFF8, 2'd2, 8'h80, 0, 0, "R10 just below");
    endtask

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: expired, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_overlap();
        t_mask();
        t_priority();
        t_overwrite();
        t_strobes();
        t_same_cycle();
        t_clear();
        t_top();
        @(negedge clk);
        chk_valid = 0; rec_valid = 0; clr = 0;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule